// File: doc/BRIEF.md
# String Operation Address Sequencer

This block produces the source and destination addresses for repeated block moves, stores and loads in a flat 16-bit address space. It has three internal registers: a source index, a destination index and an element count. Each one is written from a shared load bus while the block is idle. A start pulse captures the operation setup: direction, element size, repeat enable and operation kind. The block then walks the elements one at a time. For each element it presents the current addresses and waits for an acknowledge. On that acknowledge it moves the index registers and, in repeat mode, decrements the count.

The memory data path is not part of the block. Each element is a request/acknowledge exchange on `req` and `step_ack`. When the operation has finished, the block gives a one-cycle `done` pulse and returns to idle. The index and count registers keep their final values there, so the next operation can continue from them.

Top module: `strseq_top`

## Requirements
- R1: After a synchronous reset the block is idle. `busy`, `req` and `done` are low, and the source index, destination index and count all read zero.
- R2: `ld_src_en`, `ld_dst_en` and `ld_cnt_en` write `ld_data` into the source index, destination index and count on the next clock edge, but only while `busy` is low. While `busy` is high these load strobes have no effect.
- R3: While `req` is high, `src_addr` shows the source index and `dst_addr` shows the destination index. An element completes only in a cycle where `req` and `step_ack` are both high. `step_ack` is ignored in any other cycle.
- R4: On each completed element, every index register in use moves by 1 when `word_sel`=0 (byte) or by 2 when `word_sel`=1 (word). It is incremented when `dir_down`=0 and decremented when `dir_down`=1, with wraparound modulo 2^16.
- R5: `op_kind` is encoded as follows. 0 is a move and uses and updates both indices. 1 is a store and uses and updates only the destination index. 2 is a load and uses and updates only the source index. 3 behaves as a move. `use_src` and `use_dst` show which indices the running operation uses. An index that is not in use does not change.
- R6: With `rep_en`=1, the count drops by exactly one per completed element for both sizes. The operation keeps going until the count reaches zero and then finishes.
- R7: With `rep_en`=1 and a count of zero at start, `req` never rises. `done` pulses in the cycle after the start edge, and all registers are left unchanged.
- R8: With `rep_en`=0, exactly one element is processed, whatever the count, and the count is left unchanged.
- R9: `done` is high for exactly one cycle. That cycle follows the edge that took the final acknowledge, or the start edge in the R7 case, and `busy` is low in it.
- R10: `dir_down`, `word_sel`, `rep_en` and `op_kind` are sampled only on the accepted start edge. Changing them during an operation has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_src_en | input | 1 | Load source index from ld_data |
| ld_dst_en | input | 1 | Load destination index from ld_data |
| ld_cnt_en | input | 1 | Load count from ld_data |
| ld_data | input | AW | Shared load value |
| dir_down | input | 1 | 1 = decrement indices, 0 = increment |
| word_sel | input | 1 | 1 = word elements (step 2), 0 = bytes (step 1) |
| rep_en | input | 1 | Repeat until count is zero |
| op_kind | input | 2 | 0 move, 1 store, 2 load, 3 move |
| start | input | 1 | Start pulse, accepted while idle |
| step_ack | input | 1 | Memory side has completed the presented element |
| busy | output | 1 | Operation in progress |
| req | output | 1 | Addresses valid, waiting for step_ack |
| use_src | output | 1 | Running operation uses the source index |
| use_dst | output | 1 | Running operation uses the destination index |
| src_addr | output | AW | Source index / source address |
| dst_addr | output | AW | Destination index / destination address |
| count | output | CW | Element count register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several local rules on every cycle. An index stays still unless it is loaded or advanced. The count drops by exactly one per repeated element. The unused index holds during store and load operations, the count holds without repeat, and the captured setup stays fixed while busy. `done` never lasts two cycles, and a zero-count repeat start finishes at once. Other behaviour needs the bench's scenarios: final index and count values, element totals, modulo wraparound, direction and size combinations, acknowledge gaps, setup changes in the middle of an operation, and loads ignored while busy.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

    typedef enum logic [1:0] {
        KIND_MOVE  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_LOAD  = 2'd2,
        KIND_ALT   = 2'd3
    } op_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic     dir_down;
        logic     word;
        logic     rep;
        op_kind_e kind;
    } op_cfg_t;

    localparam int NUM_IDX  = 2;
    localparam int IDX_SRC  = 0;
    localparam int IDX_DST  = 1;
    localparam int STEP_BYTE = 1;
    localparam int STEP_WORD = 2;

    function automatic logic kind_uses_src(input op_kind_e k);
        return (k != KIND_STORE);
    endfunction

    function automatic logic kind_uses_dst(input op_kind_e k);
        return (k != KIND_LOAD);
    endfunction

    function automatic logic kind_uses(input op_kind_e k, input int which);
        return (which == IDX_SRC) ? kind_uses_src(k) : kind_uses_dst(k);
    endfunction

endpackage

// File: rtl/strseq_index.sv
module strseq_index #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          adv,
    input  logic          dir_down,
    input  logic          word,
    output logic [AW-1:0] idx
);
    import strseq_pkg::*;

    localparam logic [AW-1:0] INC_B = AW'(STEP_BYTE);
    localparam logic [AW-1:0] INC_W = AW'(STEP_WORD);

    logic [AW-1:0] idx_q;
    logic [AW-1:0] step_amt;
    logic [AW-1:0] idx_nxt;

    always_comb begin
        step_amt = word ? INC_W : INC_B;
        idx_nxt  = dir_down ? (idx_q - step_amt) : (idx_q + step_amt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (ld) begin
            idx_q <= ld_val;
        end else if (adv) begin
            idx_q <= idx_nxt;
        end
    end

    assign idx = idx_q;

    // R3: an index only moves when loaded or advanced
    p_idx_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ld && !adv) |=> $stable(idx_q));

    // R4: an advance always changes the index (step is nonzero)
    p_idx_moves_r4: assert property (@(posedge clk) disable iff (rst)
        (adv && !ld) |=> (idx_q != $past(idx_q)));

endmodule

// File: rtl/strseq_count.sv
module strseq_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          is_zero,
    output logic          is_one
);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld) begin
            cnt_q <= ld_val;
        end else if (dec) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    always_comb begin
        cnt     = cnt_q;
        is_zero = (cnt_q == '0);
        is_one  = (cnt_q == CNT_ONE);
    end

    // R6: one decrement per repeated element
    p_cnt_dec_r6: assert property (@(posedge clk) disable iff (rst)
        (dec && !ld) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    // R6: a decrement never starts from zero
    p_cnt_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        dec |-> !is_zero);

endmodule

// File: rtl/strseq_ctrl.sv
module strseq_ctrl (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                step_ack,
    input  strseq_pkg::op_cfg_t cfg_in,
    input  logic                cnt_zero,
    input  logic                cnt_one,
    output strseq_pkg::op_cfg_t cfg_q,
    output logic                idle,
    output logic                step,
    output logic                dec,
    output logic                done
);
    import strseq_pkg::*;

    seq_state_e state_q, state_d;
    op_cfg_t    cfg_r;
    logic       done_q;
    logic       accept;
    logic       skip;
    logic       last;

    always_comb begin
        accept  = (state_q == ST_IDLE) && start;
        skip    = accept && cfg_in.rep && cnt_zero;
        step    = (state_q == ST_ACTIVE) && step_ack;
        last    = step && (!cfg_r.rep || cnt_one);
        dec     = step && cfg_r.rep;
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (accept && !skip) state_d = ST_ACTIVE;
            ST_ACTIVE: if (last)            state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_r   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= skip || last;
            if (accept) begin
                cfg_r <= cfg_in;
            end
        end
    end

    assign cfg_q = cfg_r;
    assign idle  = (state_q == ST_IDLE);
    assign done  = done_q;

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R9: done only appears while idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (state_q == ST_IDLE));

    // R7: a zero-count repeat start finishes at once without going active
    p_zero_skip_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && cfg_in.rep && cnt_zero) |=> (done_q && state_q == ST_IDLE));

    // R10: captured setup holds while an operation runs
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACTIVE) |=> $stable(cfg_r));

endmodule

// File: rtl/strseq_top.sv
module strseq_top #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_src_en,
    input  logic          ld_dst_en,
    input  logic          ld_cnt_en,
    input  logic [AW-1:0] ld_data,
    input  logic          dir_down,
    input  logic          word_sel,
    input  logic          rep_en,
    input  logic [1:0]    op_kind,
    input  logic          start,
    input  logic          step_ack,
    output logic          busy,
    output logic          req,
    output logic          use_src,
    output logic          use_dst,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [CW-1:0] count,
    output logic          done
);
    import strseq_pkg::*;

    op_cfg_t       cfg_in;
    op_cfg_t       cfg_q;
    logic          idle;
    logic          step;
    logic          dec;
    logic          cnt_zero;
    logic          cnt_one;
    logic [AW-1:0] idx   [NUM_IDX];
    logic          ld_en [NUM_IDX];

    always_comb begin
        cfg_in.dir_down   = dir_down;
        cfg_in.word       = word_sel;
        cfg_in.rep        = rep_en;
        cfg_in.kind       = op_kind_e'(op_kind);
        ld_en[IDX_SRC]    = ld_src_en && idle;
        ld_en[IDX_DST]    = ld_dst_en && idle;
    end

    strseq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .step_ack (step_ack),
        .cfg_in   (cfg_in),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .cfg_q    (cfg_q),
        .idle     (idle),
        .step     (step),
        .dec      (dec),
        .done     (done)
    );

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
        logic adv_g;
        assign adv_g = step && kind_uses(cfg_q.kind, g);
        strseq_index #(.AW(AW)) u_index (
            .clk      (clk),
            .rst      (rst),
            .ld       (ld_en[g]),
            .ld_val   (ld_data),
            .adv      (adv_g),
            .dir_down (cfg_q.dir_down),
            .word     (cfg_q.word),
            .idx      (idx[g])
        );
    end

    strseq_count #(.CW(CW)) u_count (
        .clk     (clk),
        .rst     (rst),
        .ld      (ld_cnt_en && idle),
        .ld_val  (ld_data[CW-1:0]),
        .dec     (dec),
        .cnt     (count),
        .is_zero (cnt_zero),
        .is_one  (cnt_one)
    );

    assign busy     = !idle;
    assign req      = !idle;
    assign use_src  = !idle && kind_uses_src(cfg_q.kind);
    assign use_dst  = !idle && kind_uses_dst(cfg_q.kind);
    assign src_addr = idx[IDX_SRC];
    assign dst_addr = idx[IDX_DST];

    // R5: a store leaves the source index alone
    p_store_src_r5: assert property (@(posedge clk) disable iff (rst)
        (req && step_ack && cfg_q.kind == KIND_STORE) |=> $stable(src_addr));

    // R5: a load leaves the destination index alone
    p_load_dst_r5: assert property (@(posedge clk) disable iff (rst)
        (req && step_ack && cfg_q.kind == KIND_LOAD) |=> $stable(dst_addr));

    // R8: without repeat the count is untouched by a step
    p_norep_cnt_r8: assert property (@(posedge clk) disable iff (rst)
        (req && step_ack && !cfg_q.rep) |=> $stable(count));

    // R8: without repeat one acknowledge ends the operation
    p_norep_single_r8: assert property (@(posedge clk) disable iff (rst)
        (req && step_ack && !cfg_q.rep) |=> (done && !busy));

    // R2: count load is ignored while busy and not stepping
    p_ld_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && ld_cnt_en && !step_ack) |=> $stable(count));

endmodule

// File: tb/strseq_top_bench.sv
module strseq_top_bench;

    typedef struct packed {
        logic [15:0] src;
        logic [15:0] dst;
        logic [15:0] cnt;
        logic        dir;
        logic        word;
        logic        rep;
        logic [1:0]  kind;
        logic [15:0] e_src;
        logic [15:0] e_dst;
        logic [15:0] e_cnt;
        logic [7:0]  e_n;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R4 R6: byte up, move, repeat 3
        '{16'h1000, 16'h2000, 16'd3, 1'b0, 1'b0, 1'b1, 2'd0, 16'h1003, 16'h2003, 16'd0, 8'd3},
        // R4 R6: word down, move, repeat 3
        '{16'h1000, 16'h2000, 16'd3, 1'b1, 1'b1, 1'b1, 2'd0, 16'h0FFA, 16'h1FFA, 16'd0, 8'd3},
        // R8: word up, no repeat, count 5 kept
        '{16'h0100, 16'h0200, 16'd5, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0102, 16'h0202, 16'd5, 8'd1},
        // R5: store, word up, repeat 2
        '{16'h0100, 16'h0200, 16'd2, 1'b0, 1'b1, 1'b1, 2'd1, 16'h0100, 16'h0204, 16'd0, 8'd2},
        // R5: load, byte down, repeat 4
        '{16'h0010, 16'h0300, 16'd4, 1'b1, 1'b0, 1'b1, 2'd2, 16'h000C, 16'h0300, 16'd0, 8'd4},
        // R4: wrap modulo 2^16, word up
        '{16'hFFFF, 16'h0000, 16'd2, 1'b0, 1'b1, 1'b1, 2'd3, 16'h0003, 16'h0004, 16'd0, 8'd2},
        // R7: repeat with zero count
        '{16'h0500, 16'h0600, 16'd0, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0500, 16'h0600, 16'd0, 8'd0},
        // R8: zero count without repeat still moves one element
        '{16'h0500, 16'h0600, 16'd0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0501, 16'h0601, 16'd0, 8'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_src_en = 1'b0, ld_dst_en = 1'b0, ld_cnt_en = 1'b0;
    logic [15:0] ld_data = '0;
    logic        dir_down = 1'b0, word_sel = 1'b0, rep_en = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic        start = 1'b0, step_ack = 1'b0;
    logic        busy, req, use_src, use_dst, done;
    logic [15:0] src_addr, dst_addr, count;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    strseq_top u_strseq_top (
        .clk(clk), .rst(rst),
        .ld_src_en(ld_src_en), .ld_dst_en(ld_dst_en), .ld_cnt_en(ld_cnt_en),
        .ld_data(ld_data), .dir_down(dir_down), .word_sel(word_sel),
        .rep_en(rep_en), .op_kind(op_kind), .start(start), .step_ack(step_ack),
        .busy(busy), .req(req), .use_src(use_src), .use_dst(use_dst),
        .src_addr(src_addr), .dst_addr(dst_addr), .count(count), .done(done)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog act=%0d exp=<20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic load_regs(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c);
        @(negedge clk); ld_src_en = 1'b1; ld_data = s;
        @(negedge clk); ld_src_en = 1'b0; ld_dst_en = 1'b1; ld_data = d;
        @(negedge clk); ld_dst_en = 1'b0; ld_cnt_en = 1'b1; ld_data = c;
        @(negedge clk); ld_cnt_en = 1'b0;
    endtask

    function automatic logic [15:0] stepv(input logic [15:0] v, input logic dn, input logic w);
        logic [15:0] amt;
        amt = w ? 16'd2 : 16'd1;
        return dn ? v - amt : v + amt;
    endfunction

    // gap: acknowledge every other cycle; flip: change setup inputs mid-run
    task automatic run_op(input vec_t v, input logic gap, input logic flip);
        logic [15:0] ms, md;
        int n;
        int it;
        load_regs(v.src, v.dst, v.cnt);
        ms = v.src; md = v.dst; n = 0; it = 0;
        dir_down = v.dir; word_sel = v.word; rep_en = v.rep; op_kind = v.kind;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (req) begin
            chk("R5 use_src", {31'd0, use_src}, {31'd0, v.kind != 2'd1});
            chk("R5 use_dst", {31'd0, use_dst}, {31'd0, v.kind != 2'd2});
        end
        if (flip) begin
            dir_down = ~v.dir; word_sel = ~v.word; rep_en = ~v.rep; op_kind = 2'd1;
        end
        while (!done && it < 200) begin
            if (req) begin
                chk("R3 src_addr", {16'd0, src_addr}, {16'd0, ms});
                chk("R3 dst_addr", {16'd0, dst_addr}, {16'd0, md});
                if (!gap || it[0]) begin
                    step_ack = 1'b1;
                    n = n + 1;
                    if (v.kind != 2'd1) ms = stepv(ms, v.dir, v.word);
                    if (v.kind != 2'd2) md = stepv(md, v.dir, v.word);
                end else begin
                    step_ack = 1'b0;
                end
            end else begin
                step_ack = 1'b0;
            end
            it = it + 1;
            @(negedge clk);
        end
        step_ack = 1'b0;
        chk("R9 done seen", {31'd0, done}, 32'd1);
        chk("R9 busy low at done", {31'd0, busy}, 32'd0);
        chk("R6 R8 element total", n, {24'd0, v.e_n});
        chk("R4 final src", {16'd0, src_addr}, {16'd0, v.e_src});
        chk("R4 final dst", {16'd0, dst_addr}, {16'd0, v.e_dst});
        chk("R6 final count", {16'd0, count}, {16'd0, v.e_cnt});
        @(negedge clk);
        chk("R9 done single cycle", {31'd0, done}, 32'd0);
        dir_down = 1'b0; word_sel = 1'b0; rep_en = 1'b0; op_kind = 2'd0;
    endtask

    initial begin
        vec_t w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 req", {31'd0, req}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 src", {16'd0, src_addr}, 32'd0);
        chk("R1 dst", {16'd0, dst_addr}, 32'd0);
        chk("R1 count", {16'd0, count}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i], 1'b0, 1'b0);
        end

        // R3: acknowledge gaps; addresses hold while waiting
        run_op(VECS[1], 1'b1, 1'b0);

        // R10: setup inputs changed after start have no effect
        run_op(VECS[0], 1'b0, 1'b1);
        run_op(VECS[4], 1'b1, 1'b1);

        // R3: acknowledge while idle is ignored
        load_regs(16'h4000, 16'h5000, 16'd7);
        step_ack = 1'b1;
        repeat (3) @(negedge clk);
        step_ack = 1'b0;
        chk("R3 idle ack src", {16'd0, src_addr}, 32'h4000);
        chk("R3 idle ack dst", {16'd0, dst_addr}, 32'h5000);
        chk("R3 idle ack count", {16'd0, count}, 32'd7);
        chk("R3 idle ack no done", {31'd0, done}, 32'd0);

        // R2: loads while busy are ignored
        dir_down = 1'b0; word_sel = 1'b0; rep_en = 1'b1; op_kind = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ld_src_en = 1'b1; ld_dst_en = 1'b1; ld_cnt_en = 1'b1; ld_data = 16'h7777;
        @(negedge clk);
        ld_src_en = 1'b0; ld_dst_en = 1'b0; ld_cnt_en = 1'b0;
        chk("R2 src load ignored", {16'd0, src_addr}, 32'h4000);
        chk("R2 dst load ignored", {16'd0, dst_addr}, 32'h5000);
        chk("R2 count load ignored", {16'd0, count}, 32'd7);
        while (!done && cycles < 15000) begin
            step_ack = req;
            @(negedge clk);
        end
        step_ack = 1'b0;
        chk("R6 busy-load run src", {16'd0, src_addr}, 32'h4007);
        chk("R6 busy-load run count", {16'd0, count}, 32'd0);

        // R2: load while idle does take effect
        load_regs(16'h1234, 16'h5678, 16'd9);
        chk("R2 idle load src", {16'd0, src_addr}, 32'h1234);
        chk("R2 idle load dst", {16'd0, dst_addr}, 32'h5678);
        chk("R2 idle load count", {16'd0, count}, 32'd9);

        // R1: reset mid-operation returns to the reset state
        w = VECS[0];
        rep_en = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears busy", {31'd0, busy}, 32'd0);
        chk("R1 reset clears count", {16'd0, count}, 32'd0);
        chk("R1 reset clears src", {16'd0, src_addr}, 32'd0);
        if (w.e_n == 8'd0) $display("unused");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule